// File: doc/BRIEF.md
# Program Counter Sequencer with Conditional Skip

This block owns the program counter of a small accumulator-based controller core. Each cycle the decoder hands it one decoded control operation with its literal field, the current accumulator (W) value, the byte under test with a bit position, and the zero result of the ALU. From these it computes the address of the next instruction. That address can be the next sequential one, an absolute 11-bit target, a signed relative displacement, a W-relative displacement or a W-addressed call. It can also be an address popped from a circular eight-entry return stack.

Conditional execution never jumps. A bit test or a count-to-zero test instead marks the following instruction as skipped. When that instruction arrives it is flushed and retires as a no-op: the PC advances by one, and it has no stack, W or interrupt-enable effect. One return form also hands an 8-bit literal to the register file as a W load. A second return form sets the global interrupt enable. No control operation touches any status flag.

The instruction input is a valid-only stream. With `instr_valid` low the block holds all of its state. No back-pressure exists on either side: the sequencer accepts one operation per valid cycle, and the W-load output is a one-cycle pulse that the register file must always accept. Outputs are registered and reflect the operation in the cycle after it is presented. The stack overflow and underflow pins are single-cycle pulses.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc` is 0, `gie` is 0, and `w_ld_valid`, `stk_ovf` and `stk_unf` are 0. The return stack is empty and all its entries are zero.
- R2: With `instr_valid` low nothing changes. A valid operation with code 0 (sequential), or any unused code 13 to 15, sets `pc` to `pc+1` modulo 2^11.
- R3: Code 1 (jump) loads `pc` with `lit[10:0]`. Code 4 (call) does the same and pushes `pc+1`.
- R4: Code 2 (relative branch) sets `pc` to `pc+1` plus `lit[8:0]` read as a signed two's-complement value, modulo 2^11.
- R5: Code 3 (W branch) sets `pc` to `pc+1` plus W read as unsigned. Code 5 (W call) pushes `pc+1` and loads `pc` with W zero-extended.
- R6: Code 6 (return) pops the most recently pushed address into `pc`. Returns come back in last-in, first-out order.
- R7: Code 7 (literal return) pops like R6. In the same cycle as the PC update, it raises `w_ld_valid` for one cycle with `w_ld_data = lit[7:0]`.
- R8: Code 8 (interrupt return) pops like R6 and sets `gie` to 1, which then stays 1.
- R9: Code 9 marks the next operation skipped when bit `bit_pos` of `test_byte` is 0. Code 10 does so when that bit is 1. Either way `pc` advances by one.
- R10: Codes 11 (decrement test) and 12 (increment test) mark the next operation skipped when `zero_res` is 1. Either way `pc` advances by one.
- R11: A skipped operation only advances `pc` by one. It pushes nothing, pops nothing, raises no W load, leaves `gie` alone and sets no further skip. The skip mark lasts across idle cycles until the next valid operation.
- R12: The stack is circular with 8 entries. A push onto a full stack pulses `stk_ovf` one cycle after and overwrites the oldest entry, so the newest eight addresses remain.
- R13: A pop from an empty stack pulses `stk_unf` one cycle after. It still loads `pc` with the circular entry below the stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Decoded control operation code (see requirements) |
| lit | input | 11 | Literal field: target, displacement or W literal |
| wreg | input | 8 | Current W value |
| test_byte | input | 8 | Register byte examined by the bit tests |
| bit_pos | input | 3 | Bit position selected by the bit tests |
| zero_res | input | 1 | Increment/decrement result was zero |
| pc | output | 11 | Address of the operation to present next |
| w_ld_valid | output | 1 | One-cycle request to load W |
| w_ld_data | output | 8 | Value for W when `w_ld_valid` is high |
| gie | output | 1 | Global interrupt enable |
| stk_ovf | output | 1 | Push onto a full stack happened |
| stk_unf | output | 1 | Pop from an empty stack happened |

## Verification
The bench sweeps every 9-bit displacement and every W value, because a branch that sign-extends the wrong way or extends W as signed lands far from its target in half the cases. Both bit tests are tried at all eight positions against bytes of mixed polarity, and each test is followed by a jump, so a wrongly inverted or misindexed test shows up as a taken or missed jump. Skipped calls, returns and tests check that a flushed operation still pushes, pops, loads W or chains a second skip in a flawed design. A run of ten calls and ten returns crosses both stack limits: a wrong wrap or a missing flag shows up as a wrong return address or a missing pulse.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int PC_W   = 11;
  localparam int DATA_W = 8;
  localparam int OFS_W  = 9;

  typedef enum logic [3:0] {
    OP_SEQ    = 4'd0,
    OP_JMP    = 4'd1,
    OP_BREL   = 4'd2,
    OP_BW     = 4'd3,
    OP_CALL   = 4'd4,
    OP_CALLW  = 4'd5,
    OP_RET    = 4'd6,
    OP_RETLIT = 4'd7,
    OP_RETINT = 4'd8,
    OP_SKCLR  = 4'd9,
    OP_SKSET  = 4'd10,
    OP_DECSZ  = 4'd11,
    OP_INCSZ  = 4'd12
  } ctl_op_e;
endpackage

// File: rtl/pcseq_retstack.sv
module pcseq_retstack #(
  parameter int DEPTH = 8,
  parameter int DW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          ovf,
  output logic          unf
);
  localparam int SP_W = $clog2(DEPTH);
  localparam int CW   = SP_W + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [SP_W-1:0] sp;
  logic [CW-1:0] cnt;

  assign rd_data = mem[sp - 1'b1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      sp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      if (push) begin
        mem[sp] <= wr_data;
        sp      <= sp + 1'b1;
        if (cnt == FULL) ovf <= 1'b1;
        else             cnt <= cnt + 1'b1;
      end else if (pop) begin
        sp <= sp - 1'b1;
        if (cnt == '0) unf <= 1'b1;
        else           cnt <= cnt - 1'b1;
      end
    end
  end

  // R6: the value just pushed is what a pop would return next
  p_lifo_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> rd_data == $past(wr_data));
  // R12: occupancy never exceeds the depth
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  // R12: an overflow pulse follows only a push
  p_ovf_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(push) && cnt == FULL);
  // R13: an underflow pulse follows only a pop of an empty stack
  p_unf_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> $past(pop) && cnt == '0);
endmodule

// File: rtl/pcseq_skip.sv
module pcseq_skip
  import pcseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    instr_valid,
  input  ctl_op_e                 op,
  input  logic [DW-1:0]           test_byte,
  input  logic [$clog2(DW)-1:0]   bit_pos,
  input  logic                    zero_res,
  output logic                    skip_q
);
  logic sel_bit;
  logic cond;

  assign sel_bit = test_byte[bit_pos];

  always_comb begin
    case (op)
      OP_SKCLR:         cond = ~sel_bit;
      OP_SKSET:         cond = sel_bit;
      OP_DECSZ,
      OP_INCSZ:         cond = zero_res;
      default:          cond = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           skip_q <= 1'b0;
    else if (instr_valid) skip_q <= ~skip_q & cond;
  end

  // R11: a flushed operation never arms another skip
  p_single_skip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q && instr_valid |=> !skip_q);
  // R11: the skip mark survives idle cycles
  p_skip_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(skip_q));
endmodule

// File: rtl/pcseq_flow.sv
module pcseq_flow
  import pcseq_pkg::*;
#(
  parameter int PW = 11,
  parameter int DW = 8,
  parameter int OW = 9
) (
  input  ctl_op_e        op,
  input  logic [PW-1:0]  pc,
  input  logic [PW-1:0]  lit,
  input  logic [DW-1:0]  wreg,
  input  logic [PW-1:0]  ret_addr,
  output logic [PW-1:0]  seq_pc,
  output logic [PW-1:0]  next_pc,
  output logic           push,
  output logic           pop,
  output logic           ld_w,
  output logic           set_gie
);
  logic [PW-1:0] rel_ofs;
  logic [PW-1:0] w_ext;

  generate
    if (PW > OW) begin : g_sext
      assign rel_ofs = {{(PW-OW){lit[OW-1]}}, lit[OW-1:0]};
    end else begin : g_trunc
      assign rel_ofs = lit;
    end
    if (PW > DW) begin : g_zext
      assign w_ext = {{(PW-DW){1'b0}}, wreg};
    end else begin : g_wtrunc
      assign w_ext = wreg[PW-1:0];
    end
  endgenerate

  assign seq_pc = pc + 1'b1;

  always_comb begin
    next_pc = seq_pc;
    push    = 1'b0;
    pop     = 1'b0;
    ld_w    = 1'b0;
    set_gie = 1'b0;
    case (op)
      OP_JMP:    next_pc = lit;
      OP_BREL:   next_pc = seq_pc + rel_ofs;
      OP_BW:     next_pc = seq_pc + w_ext;
      OP_CALL:   begin next_pc = lit;   push = 1'b1; end
      OP_CALLW:  begin next_pc = w_ext; push = 1'b1; end
      OP_RET:    begin next_pc = ret_addr; pop = 1'b1; end
      OP_RETLIT: begin next_pc = ret_addr; pop = 1'b1; ld_w = 1'b1; end
      OP_RETINT: begin next_pc = ret_addr; pop = 1'b1; set_gie = 1'b1; end
      default:   next_pc = seq_pc;
    endcase
  end

  // R6: push and pop are never requested together
  always_comb begin
    a_push_pop_excl_r6: assert (!(push && pop));
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int PCW       = PC_W,
  parameter int WW        = DATA_W,
  parameter int BOFS_W    = OFS_W,
  parameter int STK_DEPTH = 8,
  parameter logic [PCW-1:0] RESET_PC = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   instr_valid,
  input  logic [3:0]             op,
  input  logic [PCW-1:0]         lit,
  input  logic [WW-1:0]          wreg,
  input  logic [WW-1:0]          test_byte,
  input  logic [$clog2(WW)-1:0]  bit_pos,
  input  logic                   zero_res,
  output logic [PCW-1:0]         pc,
  output logic                   w_ld_valid,
  output logic [WW-1:0]          w_ld_data,
  output logic                   gie,
  output logic                   stk_ovf,
  output logic                   stk_unf
);
  ctl_op_e op_e;
  logic skip_q, issue;
  logic [PCW-1:0] seq_pc, next_pc, ret_addr;
  logic push_r, pop_r, ld_w, set_gie;

  assign op_e  = ctl_op_e'(op);
  assign issue = instr_valid & ~skip_q;

  pcseq_skip #(.DW(WW)) u_skip (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .op(op_e),
    .test_byte(test_byte), .bit_pos(bit_pos), .zero_res(zero_res),
    .skip_q(skip_q));

  pcseq_flow #(.PW(PCW), .DW(WW), .OW(BOFS_W)) u_flow (
    .op(op_e), .pc(pc), .lit(lit), .wreg(wreg), .ret_addr(ret_addr),
    .seq_pc(seq_pc), .next_pc(next_pc), .push(push_r), .pop(pop_r),
    .ld_w(ld_w), .set_gie(set_gie));

  pcseq_retstack #(.DEPTH(STK_DEPTH), .DW(PCW)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(issue & push_r), .pop(issue & pop_r),
    .wr_data(seq_pc), .rd_data(ret_addr), .ovf(stk_ovf), .unf(stk_unf));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc         <= RESET_PC;
      w_ld_valid <= 1'b0;
      w_ld_data  <= '0;
      gie        <= 1'b0;
    end else begin
      w_ld_valid <= issue & ld_w;
      if (issue & ld_w)    w_ld_data <= lit[WW-1:0];
      if (issue & set_gie) gie       <= 1'b1;
      if (instr_valid)     pc        <= skip_q ? seq_pc : next_pc;
    end
  end

  // R2: idle cycles leave the PC alone
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(pc));
  // R11: a flushed operation just steps the PC
  p_flush_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q && instr_valid |=> pc == $past(pc) + PCW'(1));
  // R3: an unskipped jump lands on its literal
  p_jump_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue && op_e == OP_JMP |=> pc == $past(lit));
  // R7: a W load only follows an executed literal return
  p_wload_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    w_ld_valid |-> $past(instr_valid && !skip_q && op == 4'd7));
  // R8: interrupt enable rises only on an executed interrupt return
  p_gie_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gie) |-> $past(instr_valid && !skip_q && op == 4'd8));
  // R8: once set, interrupt enable stays set
  p_gie_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gie) |-> 1'b0);
endmodule

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;
  import pcseq_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [3:0] op = '0;
  logic [10:0] lit = '0;
  logic [7:0] wreg = '0, test_byte = '0;
  logic [2:0] bit_pos = '0;
  logic zero_res = 1'b0;
  logic [10:0] pc;
  logic w_ld_valid, gie, stk_ovf, stk_unf;
  logic [7:0] w_ld_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pc_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .op(op), .lit(lit),
    .wreg(wreg), .test_byte(test_byte), .bit_pos(bit_pos), .zero_res(zero_res),
    .pc(pc), .w_ld_valid(w_ld_valid), .w_ld_data(w_ld_data), .gie(gie),
    .stk_ovf(stk_ovf), .stk_unf(stk_unf));

  // reference state kept from the requirements
  logic [10:0] m_pc = '0;
  logic [10:0] m_stk [8];
  int m_sp = 0, m_cnt = 0;
  bit m_gie = 0, m_skip = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] o, input logic [10:0] l, input logic [7:0] w,
                      input logic [7:0] tb, input logic [2:0] bp, input bit z,
                      input bit v, input string tag);
    logic [10:0] seq, nxt;
    bit e_wld = 0, e_ovf = 0, e_unf = 0, do_push = 0, do_pop = 0;
    nxt = m_pc;
    seq = m_pc + 11'd1;
    if (v) begin
      if (m_skip) begin
        nxt = seq;
        m_skip = 0;
      end else begin
        nxt = seq;
        case (o)
          4'd1: nxt = l;
          4'd2: nxt = seq + {{2{l[8]}}, l[8:0]};
          4'd3: nxt = seq + {3'b000, w};
          4'd4: begin nxt = l; do_push = 1; end
          4'd5: begin nxt = {3'b000, w}; do_push = 1; end
          4'd6: do_pop = 1;
          4'd7: begin do_pop = 1; e_wld = 1; end
          4'd8: begin do_pop = 1; m_gie = 1; end
          4'd9:  m_skip = !tb[bp];
          4'd10: m_skip = tb[bp];
          4'd11, 4'd12: m_skip = z;
          default: ;
        endcase
        if (do_push) begin
          m_stk[m_sp] = seq;
          m_sp = (m_sp + 1) % 8;
          if (m_cnt == 8) e_ovf = 1; else m_cnt++;
        end
        if (do_pop) begin
          m_sp = (m_sp + 7) % 8;
          nxt = m_stk[m_sp];
          if (m_cnt == 0) e_unf = 1; else m_cnt--;
        end
      end
    end
    m_pc = nxt;
    instr_valid = v; op = o; lit = l; wreg = w; test_byte = tb; bit_pos = bp; zero_res = z;
    @(posedge clk);
    #1;
    chk(tag, "pc", pc, nxt);
    chk(tag, "w_ld_valid", w_ld_valid, e_wld);
    if (e_wld) chk(tag, "w_ld_data", w_ld_data, l[7:0]);
    chk(tag, "gie", gie, m_gie);
    chk(tag, "stk_ovf", stk_ovf, e_ovf);
    chk(tag, "stk_unf", stk_unf, e_unf);
  endtask

  task automatic go(input logic [10:0] a, input string tag);
    step(4'd1, a, 8'h00, 8'h00, 3'd0, 0, 1, tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    repeat (2) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "pc", pc, 0);
    chk("R1", "gie", gie, 0);
    chk("R1", "w_ld_valid", w_ld_valid, 0);
    chk("R1", "stk_ovf", stk_ovf, 0);
    chk("R1", "stk_unf", stk_unf, 0);
    rst_n = 1'b1;

    // R2: sequential, unused codes, idle hold, wrap
    step(4'd0, 11'h000, 8'h00, 8'h00, 3'd0, 0, 1, "R2");
    step(4'd13, 11'h7FF, 8'h00, 8'h00, 3'd0, 0, 1, "R2");
    step(4'd15, 11'h000, 8'h00, 8'h00, 3'd0, 0, 1, "R2");
    step(4'd1, 11'h555, 8'h00, 8'h00, 3'd0, 0, 0, "R2");
    step(4'd4, 11'h123, 8'h00, 8'h00, 3'd0, 0, 0, "R2");
    go(11'h7FF, "R3");
    step(4'd0, 11'h000, 8'h00, 8'h00, 3'd0, 0, 1, "R2");

    // R4: every signed displacement from two bases
    for (int b = 0; b < 2; b++)
      for (int d = 0; d < 512; d++) begin
        go(b ? 11'h003 : 11'h400, "R3");
        step(4'd2, 11'(d), 8'h00, 8'h00, 3'd0, 0, 1, "R4");
      end

    // R5: every W value for W branch; a few W calls
    for (int w = 0; w < 256; w++) begin
      go(11'h7C0, "R3");
      step(4'd3, 11'h000, 8'(w), 8'h00, 3'd0, 0, 1, "R5");
    end
    for (int w = 0; w < 256; w += 51) begin
      go(11'h2A0, "R3");
      step(4'd5, 11'h000, 8'(w), 8'h00, 3'd0, 0, 1, "R5");
      step(4'd6, 11'h000, 8'h00, 8'h00, 3'd0, 0, 1, "R6");
    end

    // R6: nested calls return in LIFO order
    step(4'd4, 11'h100, 8'h00, 8'h00, 3'd0, 0, 1, "R6");
    step(4'd4, 11'h200, 8'h00, 8'h00, 3'd0, 0, 1, "R6");
    step(4'd5, 11'h000, 8'h80, 8'h00, 3'd0, 0, 1, "R6");
    step(4'd6, 11'h000, 8'h00, 8'h00, 3'd0, 0, 1, "R6");
    // R7: literal return loads W
    step(4'd7, 11'h6A5, 8'h00, 8'h00, 3'd0, 0, 1, "R7");
    step(4'd0, 11'h000, 8'h00, 8'h00, 3'd0, 0, 1, "R7");
    // R8: interrupt return sets the enable
    step(4'd8, 11'h000, 8'h00, 8'h00, 3'd0, 0, 1, "R8");
    step(4'd0, 11'h000, 8'h00, 8'h00, 3'd0, 0, 1, "R8");

    // R9: both bit tests, every position, mixed bytes; follower jump shows skip
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 8; p++)
        for (int s = 0; s < 2; s++) begin
          logic [7:0] tbv;
          tbv = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hA5 : 8'h5A;
          step(s ? 4'd10 : 4'd9, 11'h000, 8'h00, tbv, 3'(p), 0, 1, "R9");
          go(11'h123, "R9");
        end

    // R10: counter tests
    for (int c = 0; c < 2; c++)
      for (int z = 0; z < 2; z++) begin
        step(c ? 4'd12 : 4'd11, 11'h000, 8'h00, 8'h00, 3'd0, z != 0, 1, "R10");
        go(11'h321, "R10");
      end

    // R11: skipped call, literal return, test, with idle gap
    step(4'd11, 11'h000, 8'h00, 8'h00, 3'd0, 1, 1, "R11");
    step(4'd0, 11'h000, 8'h00, 8'h00, 3'd0, 0, 0, "R11");
    step(4'd4, 11'h050, 8'h00, 8'h00, 3'd0, 0, 1, "R11");
    step(4'd12, 11'h000, 8'h00, 8'h00, 3'd0, 1, 1, "R11");
    step(4'd7, 11'h0EE, 8'h00, 8'h00, 3'd0, 0, 1, "R11");
    step(4'd10, 11'h000, 8'h00, 8'h01, 3'd0, 0, 1, "R11");
    step(4'd10, 11'h000, 8'h00, 8'h01, 3'd0, 0, 1, "R11");
    go(11'h444, "R11");
    step(4'd6, 11'h000, 8'h00, 8'h00, 3'd0, 0, 1, "R11");

    // R12 and R13: ten calls then ten returns crosses both limits
    for (int i = 0; i < 10; i++)
      step(4'd4, 11'(16 * i + 5), 8'h00, 8'h00, 3'd0, 0, 1, "R12");
    for (int i = 0; i < 10; i++)
      step(4'd6, 11'h000, 8'h00, 8'h00, 3'd0, 0, 1, i < 8 ? "R12" : "R13");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule